// File: doc/BRIEF.md
# Timer Compare Flag Unit

This block holds two time bases and a pair of shared condition flags. The frame timer is loaded with a programmed frame period. It then counts down by one on each 100 µs tick and stops at zero. While it holds zero, it raises a zero indication. The message timer is cleared when a message starts. It then counts up by one on each 1 µs tick and saturates at its maximum value.

A sequencer issues compare requests. Each request carries a counter select and a parameter value. The block compares the parameter with the selected counter and records the result in two flag bits, GP0 and GP1. The host can also write these two bits. Each bit is read in two complementary senses:

- GP0 high means "less than". GP0 low means "greater or equal".
- GP1 high means "equal". GP1 low means "not equal".

The compare request is a valid/ready stream. `cmp_ready` is held high at all times, so the block never applies back-pressure. A request is taken in every cycle where `cmp_valid` is high. The timer and host-write pins are plain control pins.

Top module: `tcf_unit`

## Requirements
- R1: After reset, both counters read 0, `frame_zero` is 1, `flag_gp0` and `flag_gp1` are 0, and `cmp_ready` is 1.
- R2: `frame_load` loads `frame_period` into the frame counter on the next edge, taking priority over `frame_tick`. Otherwise, each `frame_tick` decrements a nonzero count by one, and a count of zero holds at zero.
- R3: `frame_zero` is 1 exactly when the frame counter holds 0.
- R4: `msg_start` clears the message counter on the next edge, taking priority over `us_tick`. Otherwise, each `us_tick` increments the count by one, and the count saturates at its all-ones value.
- R5: A compare whose parameter is less than the selected counter sets GP0 to 1 and GP1 to 0 on the next edge.
- R6: A compare whose parameter equals the selected counter sets GP0 to 0 and GP1 to 1 on the next edge.
- R7: A compare whose parameter is greater than the selected counter sets GP0 to 0 and GP1 to 0 on the next edge.
- R8: `cmp_sel` = 0 selects the frame counter and `cmp_sel` = 1 selects the message counter. The comparison uses the counter value held in the request cycle, before any tick applied in that same cycle.
- R9: The outputs are complementary: `flag_lt` = GP0, `flag_ge` = not GP0, `flag_eq` = GP1, `flag_ne` = not GP1.
- R10: A host write sets GP0 from `host_wdata[0]` when `host_we[0]` is 1, and sets GP1 from `host_wdata[1]` when `host_we[1]` is 1. A bit whose enable is 0 keeps its value.
- R11: When a compare and a host write fall in the same cycle, the compare result is stored in both bits.
- R12: Without a compare or a host write, the flags keep their value, whatever the ticks or loads do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | 100 µs tick strobe for the frame counter |
| us_tick | input | 1 | 1 µs tick strobe for the message counter |
| frame_load | input | 1 | Load the frame period |
| frame_period | input | CNT_W | Frame period to load |
| msg_start | input | 1 | Message start; clears the message counter |
| cmp_valid | input | 1 | Compare request valid |
| cmp_ready | output | 1 | Compare request ready (always 1) |
| cmp_sel | input | 1 | 0 = frame counter, 1 = message counter |
| cmp_value | input | CNT_W | Compare parameter |
| host_we | input | 2 | Per-bit host write enable (bit 0 = GP0, bit 1 = GP1) |
| host_wdata | input | 2 | Host write data (bit 0 = GP0, bit 1 = GP1) |
| frame_count | output | CNT_W | Frame counter value |
| msg_count | output | CNT_W | Message counter value |
| frame_zero | output | 1 | Frame counter is zero |
| flag_gp0 | output | 1 | GP0 storage bit |
| flag_gp1 | output | 1 | GP1 storage bit |
| flag_lt | output | 1 | Less-than sense of GP0 |
| flag_ge | output | 1 | Greater-or-equal sense of GP0 |
| flag_eq | output | 1 | Equal sense of GP1 |
| flag_ne | output | 1 | Not-equal sense of GP1 |

## Verification
The bench sweeps every pair of parameter and counter value on a 4-bit build, for both counters. A swapped or off-by-one comparison would therefore show up as a wrong GP0/GP1 pair on at least one boundary.

It also targets several single-cycle corner cases:
- A tick in the same cycle as a compare. A design that compared after the tick would report "equal" one count late.
- A load in the same cycle as a tick, and a message start in the same cycle as a tick. A design with the wrong priority would leave a stale count.
- A host write in the same cycle as a compare. A design where the host wins would show the host's bits instead of the compare result.

The remaining targets are the frame counter holding at zero and the message counter saturating. A design that wrapped would read all-ones or zero, respectively.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
  typedef enum logic {
    SEL_FRAME = 1'b0,
    SEL_MSG   = 1'b1
  } tcf_sel_e;

  typedef struct packed {
    logic gp1;
    logic gp0;
  } tcf_flags_t;
endpackage

// File: rtl/tcf_frame_timer.sv
module tcf_frame_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] period,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             zero
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n)                 count <= '0;
    else if (load)              count <= period;
    else if (tick && count != '0) count <= count - ONE;
  end

  assign zero = (count == '0);
endmodule

// File: rtl/tcf_msg_timer.sv
module tcf_msg_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                  count <= '0;
    else if (clear)              count <= '0;
    else if (tick && count != TOP) count <= count + ONE;
  end
endmodule

// File: rtl/tcf_flag_store.sv
module tcf_flag_store
  import tcf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  tcf_sel_e         sel,
  input  logic [CNT_W-1:0] value,
  input  logic [CNT_W-1:0] frame_cnt,
  input  logic [CNT_W-1:0] msg_cnt,
  input  logic [1:0]       host_we,
  input  logic [1:0]       host_wdata,
  output tcf_flags_t       flags
);
  logic [CNT_W-1:0] ref_cnt;
  tcf_flags_t       cmp_res;
  tcf_flags_t       host_res;

  always_comb begin
    ref_cnt     = (sel == SEL_MSG) ? msg_cnt : frame_cnt;
    cmp_res.gp0 = (value < ref_cnt);
    cmp_res.gp1 = (value == ref_cnt);
    host_res.gp0 = host_we[0] ? host_wdata[0] : flags.gp0;
    host_res.gp1 = host_we[1] ? host_wdata[1] : flags.gp1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    flags <= '0;
    else if (fire) flags <= cmp_res;
    else           flags <= host_res;
  end
endmodule

// File: rtl/tcf_unit.sv
module tcf_unit
  import tcf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic             us_tick,
  input  logic             frame_load,
  input  logic [CNT_W-1:0] frame_period,
  input  logic             msg_start,
  input  logic             cmp_valid,
  output logic             cmp_ready,
  input  logic             cmp_sel,
  input  logic [CNT_W-1:0] cmp_value,
  input  logic [1:0]       host_we,
  input  logic [1:0]       host_wdata,
  output logic [CNT_W-1:0] frame_count,
  output logic [CNT_W-1:0] msg_count,
  output logic             frame_zero,
  output logic             flag_gp0,
  output logic             flag_gp1,
  output logic             flag_lt,
  output logic             flag_ge,
  output logic             flag_eq,
  output logic             flag_ne
);
  tcf_flags_t flags;
  tcf_sel_e   sel_e;

  assign cmp_ready = 1'b1;
  assign sel_e     = tcf_sel_e'(cmp_sel);

  tcf_frame_timer #(.CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .load(frame_load), .period(frame_period),
    .tick(frame_tick), .count(frame_count), .zero(frame_zero)
  );

  tcf_msg_timer #(.CNT_W(CNT_W)) u_msg (
    .clk(clk), .rst_n(rst_n), .clear(msg_start), .tick(us_tick),
    .count(msg_count)
  );

  tcf_flag_store #(.CNT_W(CNT_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .fire(cmp_valid && cmp_ready), .sel(sel_e),
    .value(cmp_value), .frame_cnt(frame_count), .msg_cnt(msg_count),
    .host_we(host_we), .host_wdata(host_wdata), .flags(flags)
  );

  assign flag_gp0 = flags.gp0;
  assign flag_gp1 = flags.gp1;
  assign flag_lt  = flags.gp0;
  assign flag_ge  = ~flags.gp0;
  assign flag_eq  = flags.gp1;
  assign flag_ne  = ~flags.gp1;
endmodule

// File: rtl/tcf_unit_checker.sv
module tcf_unit_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_load,
  input logic             msg_start,
  input logic             cmp_valid,
  input logic             cmp_sel,
  input logic [CNT_W-1:0] cmp_value,
  input logic [1:0]       host_we,
  input logic [1:0]       host_wdata,
  input logic [CNT_W-1:0] frame_count,
  input logic [CNT_W-1:0] msg_count,
  input logic             flag_gp0,
  input logic             flag_gp1
);
  logic [CNT_W-1:0] sel_cnt;
  assign sel_cnt = cmp_sel ? msg_count : frame_count;

  a_r5_less: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_value < sel_cnt) |=> (flag_gp0 && !flag_gp1));

  a_r6_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_value == sel_cnt) |=> (!flag_gp0 && flag_gp1));

  a_r7_greater: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_value > sel_cnt) |=> (!flag_gp0 && !flag_gp1));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_valid && host_we == 2'b00) |=> $stable({flag_gp1, flag_gp0}));

  a_r10_host_gp0: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_valid && host_we[0]) |=> (flag_gp0 == $past(host_wdata[0])));

  a_r2_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_load |=> (frame_count <= $past(frame_count)));

  a_r4_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_start |=> (msg_count >= $past(msg_count)));
endmodule

bind tcf_unit tcf_unit_checker #(.CNT_W(CNT_W)) u_tcf_chk (
  .clk(clk), .rst_n(rst_n), .frame_load(frame_load), .msg_start(msg_start),
  .cmp_valid(cmp_valid), .cmp_sel(cmp_sel), .cmp_value(cmp_value),
  .host_we(host_we), .host_wdata(host_wdata), .frame_count(frame_count),
  .msg_count(msg_count), .flag_gp0(flag_gp0), .flag_gp1(flag_gp1)
);

// File: tb/test_tcf_unit.sv
`timescale 1ns/1ps
module test_tcf_unit;
  localparam int W = 4;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 0, us_tick = 0, frame_load = 0, msg_start = 0;
  logic [W-1:0] frame_period = '0, cmp_value = '0;
  logic cmp_valid = 0, cmp_sel = 0;
  logic [1:0] host_we = '0, host_wdata = '0;
  logic cmp_ready, frame_zero, flag_gp0, flag_gp1, flag_lt, flag_ge, flag_eq, flag_ne;
  logic [W-1:0] frame_count, msg_count;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tcf_unit #(.CNT_W(W)) i_tcf_unit (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .us_tick(us_tick),
    .frame_load(frame_load), .frame_period(frame_period), .msg_start(msg_start),
    .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_sel(cmp_sel),
    .cmp_value(cmp_value), .host_we(host_we), .host_wdata(host_wdata),
    .frame_count(frame_count), .msg_count(msg_count), .frame_zero(frame_zero),
    .flag_gp0(flag_gp0), .flag_gp1(flag_gp1), .flag_lt(flag_lt),
    .flag_ge(flag_ge), .flag_eq(flag_eq), .flag_ne(flag_ne)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock: inputs already driven; sample 1 ns after the edge, then idle inputs.
  task automatic cyc();
    @(posedge clk); #1;
    frame_tick = 0; us_tick = 0; frame_load = 0; msg_start = 0;
    cmp_valid = 0; host_we = '0;
  endtask

  task automatic chk_flags(input string req, input int g0, input int g1);
    chk(req, {flag_gp1, flag_gp0}, {g1[0], g0[0]});
    chk({req, "/R9"}, {flag_ne, flag_eq, flag_ge, flag_lt},
        {~g1[0], g1[0], ~g0[0], g0[0]});
  endtask

  task automatic do_cmp(input logic s, input int v);
    cmp_sel = s; cmp_value = W'(v); cmp_valid = 1; cyc();
  endtask

  initial begin
    #50000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 frame", frame_count, 0);
    chk("R1 msg", msg_count, 0);
    chk("R1 zero", frame_zero, 1);
    chk("R1 ready", cmp_ready, 1);
    chk_flags("R1 flags", 0, 0);

    // R5/R6/R7/R8 frame sweep, R3
    for (int f = 0; f <= MAXV; f++) begin
      frame_period = W'(f); frame_load = 1; cyc();
      chk("R2 load", frame_count, f);
      chk("R3 zero", frame_zero, (f == 0) ? 1 : 0);
      for (int v = 0; v <= MAXV; v++) begin
        do_cmp(1'b0, v);
        chk_flags(v < f ? "R5 frame" : (v == f ? "R6 frame" : "R7 frame"),
                  (v < f) ? 1 : 0, (v == f) ? 1 : 0);
      end
    end

    // message sweep, R4 increments
    for (int m = 0; m <= MAXV; m++) begin
      msg_start = 1; cyc();
      for (int k = 0; k < m; k++) begin us_tick = 1; cyc(); end
      chk("R4 count", msg_count, m);
      for (int v = 0; v <= MAXV; v++) begin
        do_cmp(1'b1, v);
        chk_flags(v < m ? "R5 msg" : (v == m ? "R6 msg" : "R7 msg"),
                  (v < m) ? 1 : 0, (v == m) ? 1 : 0);
      end
    end

    // R4 saturation, then start beats tick
    for (int k = 0; k < 5; k++) begin us_tick = 1; cyc(); end
    chk("R4 saturate", msg_count, MAXV);
    msg_start = 1; us_tick = 1; cyc();
    chk("R4 start priority", msg_count, 0);

    // R2 countdown and hold at zero, R3
    frame_period = 4'd3; frame_load = 1; cyc();
    for (int k = 2; k >= -1; k--) begin
      frame_tick = 1; cyc();
      chk("R2 countdown", frame_count, k < 0 ? 0 : k);
      chk("R3 zero", frame_zero, k <= 0 ? 1 : 0);
    end
    frame_period = 4'd9; frame_load = 1; frame_tick = 1; cyc();
    chk("R2 load priority", frame_count, 9);

    // R8 compare uses pre-tick value
    frame_tick = 1; do_cmp(1'b0, 9);
    chk_flags("R8 pre-tick", 0, 1);
    chk("R8 ticked", frame_count, 8);

    // R10 host writes with enables
    host_we = 2'b11; host_wdata = 2'b01; cyc();
    chk_flags("R10 both", 1, 0);
    host_we = 2'b10; host_wdata = 2'b10; cyc();
    chk_flags("R10 gp1 only", 1, 1);
    host_we = 2'b01; host_wdata = 2'b00; cyc();
    chk_flags("R10 gp0 only", 0, 1);

    // R12 ticks and loads leave flags alone
    frame_tick = 1; us_tick = 1; frame_load = 1; frame_period = 4'd2; msg_start = 1; cyc();
    chk_flags("R12 hold", 0, 1);

    // R11 compare wins: frame=2, param 0 -> less
    host_we = 2'b11; host_wdata = 2'b10; cmp_sel = 0; cmp_value = 4'd0; cmp_valid = 1; cyc();
    chk_flags("R11 compare wins", 1, 0);
    host_we = 2'b11; host_wdata = 2'b01; cmp_sel = 1; cmp_value = 4'd5; cmp_valid = 1; cyc();
    chk_flags("R11 compare wins msg", 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule